// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two levels of state. The first is a global outcome history: a shift register that records the directions of the most recent resolved branches. The second is a table of 2-bit saturating counters. Each lookup selects one counter with the exclusive-OR of the history and the word-address bits of the branch PC. The upper bit of that counter is the guess.

A fetch stage drives the lookup PC and reads the guess in the same cycle. It also reads the history value that formed the index and keeps that value with the branch. When the branch resolves, the back end sends the PC, the real direction and that saved history to the update port. The block trains the same counter that made the guess and shifts the real direction into the history. A separate restore input lets a flush load a known history value.

Top module: `gshare_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter is weakly taken, so every PC is predicted taken.
- R2: The counter index is history[9:0] XOR PC[11:2]. PC bits [1:0] and bits above 11 do not change which counter is selected. Two PC/history pairs with the same XOR share one counter.
- R3: The counter states are 2'b11 strongly taken, 2'b10 weakly taken, 2'b01 weakly not taken and 2'b00 strongly not taken. The prediction is taken (pred_taken = 1) exactly when bit 1 of the selected counter is 1.
- R4: An update with upd_taken = 1 raises the counter by one and saturates at 2'b11.
- R5: An update with upd_taken = 0 lowers the counter by one and saturates at 2'b00.
- R6: From a strong state, the prediction flips only after two consecutive contrary outcomes. A single contrary outcome leaves it unchanged.
- R7: Each update without restore sets the history to {history[8:0], upd_taken}. The newest outcome enters at bit 0 and bit 9 is discarded.
- R8: Training uses upd_hist, not the current history, to form the index, so it reaches the counter that was read at prediction time.
- R9: When restore_valid is high, the history takes restore_hist at the next edge. This overrides the shift of a simultaneous update, but that update still trains its counter.
- R10: The prediction is combinational from pred_pc and the current state. An update changes nothing until the next rising edge. With neither update nor restore, the history and all counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History value used for this lookup, to be returned on update |
| upd_valid | input | 1 | Resolved branch update strobe |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch |
| upd_hist | input | HIST_W | History snapshot saved at prediction time |
| restore_valid | input | 1 | Load history from restore_hist |
| restore_hist | input | HIST_W | History value to load |

## Verification
Each update also moves the history, so reaching one chosen counter again from the ports is the hard part. The stimulus works around this. Before every table-driven step it uses the restore input to pin the history to a chosen value. Each update then returns that pinned value as its snapshot. This lets one counter be walked through all four states, and lets aliasing and ignored PC bits be reached on purpose. Separate directed steps then release the history and check shifting, restore priority and a training index that differs from the live history.

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
  parameter int HIST_W = 10,
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              restore_valid,
  input  logic [HIST_W-1:0] restore_hist
);

  localparam int          ENTRIES = 1 << HIST_W;
  localparam logic [1:0]  CTR_INIT = 2'b10;

  logic [HIST_W-1:0] ghr;
  logic [1:0]        pht [ENTRIES];
  logic [HIST_W-1:0] rd_idx, wr_idx;
  logic [1:0]        wr_old, wr_new;

  assign rd_idx     = pred_pc[PC_LSB +: HIST_W] ^ ghr;
  assign wr_idx     = upd_pc[PC_LSB +: HIST_W] ^ upd_hist;
  assign pred_taken = pht[rd_idx][1];
  assign pred_hist  = ghr;
  assign wr_old     = pht[wr_idx];

  always_comb begin
    wr_new = wr_old;
    if (upd_taken && wr_old != 2'b11)      wr_new = wr_old + 2'd1;
    else if (!upd_taken && wr_old != 2'b00) wr_new = wr_old - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             ghr <= '0;
    else if (restore_valid) ghr <= restore_hist;
    else if (upd_valid)     ghr <= {ghr[HIST_W-2:0], upd_taken};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) pht[i] <= CTR_INIT;
    end else if (upd_valid) begin
      pht[wr_idx] <= wr_new;
    end
  end

endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk #(
  parameter int HIST_W = 10,
  parameter int PC_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pred_pc,
  input logic              pred_taken,
  input logic [HIST_W-1:0] pred_hist,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic              restore_valid,
  input logic [HIST_W-1:0] restore_hist
);

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !restore_valid) |=> pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)}); // R7

  AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> pred_hist == $past(restore_hist)); // R9

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !restore_valid) |=> $stable(pred_hist)); // R10

  AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !restore_valid && $stable(pred_pc)) |=> $stable(pred_taken)); // R10

endmodule

bind gshare_predictor gshare_predictor_chk #(.HIST_W(HIST_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
  .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .restore_valid(restore_valid), .restore_hist(restore_hist)
);

// File: tb/gshare_predictor_tb.sv
module gshare_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pred_pc, upd_pc;
  logic        pred_taken, upd_valid, upd_taken, restore_valid;
  logic [9:0]  pred_hist, upd_hist, restore_hist;
  int          n_tests = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  gshare_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist),
    .restore_valid(restore_valid), .restore_hist(restore_hist)
  );

  // {pc, history, outcome, expected prediction before the update}
  localparam logic [43:0] VEC [15] = '{
    {32'h0000_0010, 10'h000, 1'b1, 1'b1}, // R4 WT->ST
    {32'h0000_0010, 10'h000, 1'b1, 1'b1}, // R4 saturate at 11
    {32'h0000_0010, 10'h000, 1'b0, 1'b1}, // R6 ST->WT still taken
    {32'h0000_0010, 10'h000, 1'b0, 1'b1}, // R5 WT->WNT
    {32'h0000_0010, 10'h000, 1'b0, 1'b0}, // R5 WNT->SNT
    {32'h0000_0010, 10'h000, 1'b0, 1'b0}, // R5 saturate at 00
    {32'h0000_0010, 10'h000, 1'b1, 1'b0}, // R6 SNT->WNT still not taken
    {32'h0000_0010, 10'h000, 1'b1, 1'b0}, // R3 WNT->WT
    {32'h0000_0013, 10'h000, 1'b0, 1'b1}, // R2 low PC bits ignored
    {32'h1000_0010, 10'h000, 1'b1, 1'b0}, // R2 high PC bits ignored
    {32'h0000_0000, 10'h004, 1'b0, 1'b1}, // R2 alias via history
    {32'h0000_0010, 10'h3FF, 1'b0, 1'b1}, // R2 fresh index 0x3FB
    {32'h0000_0010, 10'h000, 1'b1, 1'b0}, // R2 index 4 is WNT
    {32'h0000_0FEC, 10'h000, 1'b1, 1'b0}, // R2 same index 0x3FB
    {32'h0000_0010, 10'h3FF, 1'b0, 1'b1}  // R2 0x3FB back to WT
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit uv, input logic [31:0] pc, input bit tk,
                       input logic [9:0] uh, input bit rv, input logic [9:0] rh);
    @(negedge clk);
    upd_valid = uv; upd_pc = pc; upd_taken = tk; upd_hist = uh;
    restore_valid = rv; restore_hist = rh;
    @(negedge clk);
    upd_valid = 0; restore_valid = 0;
    #1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pred_pc = 0; upd_valid = 0; upd_pc = 0; upd_taken = 0;
    upd_hist = 0; restore_valid = 0; restore_hist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(pred_hist == 10'h000, "R1 reset history", pred_hist, 0);
    for (int k = 0; k < 4; k++) begin
      pred_pc = 32'h0000_1234 * (k + 1);
      #1;
      check(pred_taken == 1'b1, "R1 reset prediction", pred_taken, 1);
    end

    for (int i = 0; i < 15; i++) begin
      logic [31:0] pc; logic [9:0] h; logic tk, ex;
      {pc, h, tk, ex} = VEC[i];
      cycle(0, 0, 0, 0, 1, h);
      pred_pc = pc;
      #1;
      check(pred_hist == h, "R9 restore before vector", pred_hist, h);
      check(pred_taken == ex, "R3 vector prediction", pred_taken, ex);
      cycle(1, pc, tk, h, 0, 0);
    end

    // R7 shift order
    cycle(0, 0, 0, 0, 1, 10'h000);
    cycle(1, 32'h200, 1, pred_hist, 0, 0);
    check(pred_hist == 10'h001, "R7 shift 1", pred_hist, 10'h001);
    cycle(1, 32'h200, 0, pred_hist, 0, 0);
    check(pred_hist == 10'h002, "R7 shift 2", pred_hist, 10'h002);
    cycle(1, 32'h200, 1, pred_hist, 0, 0);
    cycle(1, 32'h200, 1, pred_hist, 0, 0);
    check(pred_hist == 10'h00B, "R7 shift 4", pred_hist, 10'h00B);
    cycle(0, 0, 0, 0, 1, 10'h3FF);
    cycle(1, 32'h200, 0, pred_hist, 0, 0);
    check(pred_hist == 10'h3FE, "R7 msb drop", pred_hist, 10'h3FE);

    // R8 train with snapshot different from live history
    cycle(0, 0, 0, 0, 1, 10'h155);
    cycle(1, 32'h40, 0, 10'h000, 0, 0);
    cycle(0, 0, 0, 0, 1, 10'h155);
    cycle(1, 32'h40, 0, 10'h000, 0, 0);
    cycle(0, 0, 0, 0, 1, 10'h000);
    pred_pc = 32'h40; #1;
    check(pred_taken == 1'b0, "R8 snapshot entry trained", pred_taken, 0);
    cycle(0, 0, 0, 0, 1, 10'h155);
    pred_pc = 32'h40; #1;
    check(pred_taken == 1'b1, "R8 live entry untouched", pred_taken, 1);

    // R9 restore and update together
    cycle(1, 32'h80, 0, 10'h000, 1, 10'h2AA);
    check(pred_hist == 10'h2AA, "R9 restore priority", pred_hist, 10'h2AA);
    cycle(0, 0, 0, 0, 1, 10'h000);
    pred_pc = 32'h80; #1;
    check(pred_taken == 1'b0, "R9 update still trains", pred_taken, 0);

    // R10 combinational read, update seen after edge, hold when idle
    pred_pc = 32'h100;
    @(negedge clk);
    upd_valid = 1; upd_pc = 32'h100; upd_taken = 0; upd_hist = 10'h000;
    #1;
    check(pred_taken == 1'b1, "R10 before edge", pred_taken, 1);
    @(negedge clk);
    upd_valid = 0; #1;
    check(pred_taken == 1'b0, "R10 after edge", pred_taken, 0);
    repeat (3) @(negedge clk);
    #1;
    check(pred_hist == 10'h000, "R10 idle history hold", pred_hist, 0);
    check(pred_taken == 1'b0, "R10 idle counter hold", pred_taken, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule